// File: doc/BRIEF.md
# Carry-less polynomial multiply-accumulate unit

This block multiplies two W-bit operands as polynomials over GF(2). Partial products are combined with XOR, so no carries propagate. The 2W-bit product is then either written into a HI:LO result pair or XOR-folded into the value the pair already holds. The default width is 32.

The core is iterative. It retires a fixed number of multiplier bits per cycle, one by default, so an operation takes W/BITS_PER_CYC cycles. A start strobe that arrives while the unit is idle captures the operands and the mode bit. A strobe that arrives while the unit is working is dropped.

On completion the unit pulses done for one cycle. When the operation was a plain (loading) multiply, it also pulses a clear request toward the accumulator-extension register kept outside this block. An XOR-accumulate leaves that register alone, so no clear is raised.

Top module: `clmul_acc`

## Requirements
- R1: After reset, hi_o and lo_o are zero, and done_o and ext_clr_o are low.
- R2: The product is the XOR, over every bit i set in op_a_i, of op_b_i shifted left by i within a 2W-bit field.
- R3: With acc_i = 0 at start, lo_o takes product bits W-1:0 and hi_o takes product bits 2W-1:W.
- R4: With acc_i = 1 at start, lo_o becomes lo_o XOR product[W-1:0] and hi_o becomes hi_o XOR product[2W-1:W].
- R5: ext_clr_o pulses high for exactly one cycle, in the same cycle as done_o, only for an operation started with acc_i = 0.
- R6: A start accepted at clock edge k updates hi_o and lo_o at edge k+W/BITS_PER_CYC, which is edge k+32 by default. done_o is high for the single cycle that follows that edge.
- R7: A start_i pulse while an operation is in progress is ignored and does not alter the running operation or its result.
- R8: The top bit of the product, and so hi_o[W-1], is always zero.
- R9: hi_o and lo_o hold their values in every cycle in which no operation completes, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, honoured only when idle |
| acc_i | input | 1 | 0 = load product, 1 = XOR into HI:LO |
| op_a_i | input | W | Multiplier polynomial |
| op_b_i | input | W | Multiplicand polynomial |
| hi_o | output | W | Upper result half |
| lo_o | output | W | Lower result half |
| ext_clr_o | output | 1 | Clear request for the extension register |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A start taken at edge k moves HI:LO at edge k+32. done_o, together with ext_clr_o for a load, is visible in the cycle right after that edge. The bench models this with a countdown that is loaded with 32 on an accepted start and commits as it leaves 1. The model ignores strobes while the countdown is non-zero. Every output is compared on each falling edge, which is half a period after the edge that could have changed it. This catches both early and late updates.

// File: rtl/clmul_pkg.sv
package clmul_pkg;
  typedef enum logic {
    MODE_LOAD = 1'b0,
    MODE_XOR  = 1'b1
  } clmul_mode_e;
endpackage

// File: rtl/clmul_step.sv
module clmul_step #(
  parameter int W = 32
) (
  input  logic [W-1:0]   a_i,
  input  logic [2*W-1:0] b_i,
  input  logic [2*W-1:0] p_i,
  output logic [W-1:0]   a_o,
  output logic [2*W-1:0] b_o,
  output logic [2*W-1:0] p_o
);
  always_comb begin
    p_o = a_i[0] ? (p_i ^ b_i) : p_i;
    a_o = a_i >> 1;
    b_o = b_i << 1;
  end
endmodule

// File: rtl/clmul_ctrl.sv
module clmul_ctrl #(
  parameter int W            = 32,
  parameter int BITS_PER_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic busy_o,
  output logic last_o
);
  localparam int NSTEP = W / BITS_PER_CYC;
  localparam int CW    = (NSTEP > 1) ? $clog2(NSTEP) : 1;

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign load_o = start_i & ~busy_q;
  assign busy_o = busy_q;
  assign last_o = busy_q & (cnt_q == CW'(NSTEP - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (last_o) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // progress is unaffected by start while busy
  p_busy_advance_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last_o) |=> (busy_q && cnt_q == $past(cnt_q) + CW'(1)));

  p_cnt_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (int'(cnt_q) < NSTEP));

  p_last_ends_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !busy_q);
endmodule

// File: rtl/clmul_hilo.sv
module clmul_hilo
  import clmul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            commit_i,
  input  clmul_mode_e     mode_i,
  input  logic [2*W-1:0]  prod_i,
  output logic [W-1:0]    hi_o,
  output logic [W-1:0]    lo_o,
  output logic            done_o,
  output logic            ext_clr_o
);
  logic [W-1:0] hi_q, lo_q;
  logic         done_q, clr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      lo_q   <= '0;
      done_q <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      done_q <= commit_i;
      clr_q  <= commit_i & (mode_i == MODE_LOAD);
      if (commit_i) begin
        if (mode_i == MODE_XOR) begin
          hi_q <= hi_q ^ prod_i[2*W-1:W];
          lo_q <= lo_q ^ prod_i[W-1:0];
        end else begin
          hi_q <= prod_i[2*W-1:W];
          lo_q <= prod_i[W-1:0];
        end
      end
    end
  end

  assign hi_o      = hi_q;
  assign lo_o      = lo_q;
  assign done_o    = done_q;
  assign ext_clr_o = clr_q;

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> ($stable(hi_q) && $stable(lo_q)));

  p_clr_with_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q |-> done_q);

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  p_hi_msb_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hi_q[W-1]);
endmodule

// File: rtl/clmul_acc.sv
module clmul_acc
  import clmul_pkg::*;
#(
  parameter int W            = 32,
  parameter int BITS_PER_CYC = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         acc_i,
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o,
  output logic         ext_clr_o,
  output logic         done_o
);
  localparam int PW = 2 * W;

  logic          load, busy, last;
  logic [W-1:0]  a_q;
  logic [PW-1:0] b_q, p_q;
  clmul_mode_e   mode_q;

  logic [W-1:0]  a_ch [BITS_PER_CYC+1];
  logic [PW-1:0] b_ch [BITS_PER_CYC+1];
  logic [PW-1:0] p_ch [BITS_PER_CYC+1];

  assign a_ch[0] = a_q;
  assign b_ch[0] = b_q;
  assign p_ch[0] = p_q;

  for (genvar g = 0; g < BITS_PER_CYC; g++) begin : g_step
    clmul_step #(.W(W)) u_step (
      .a_i(a_ch[g]),   .b_i(b_ch[g]),   .p_i(p_ch[g]),
      .a_o(a_ch[g+1]), .b_o(b_ch[g+1]), .p_o(p_ch[g+1])
    );
  end

  clmul_ctrl #(.W(W), .BITS_PER_CYC(BITS_PER_CYC)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .load_o(load), .busy_o(busy), .last_o(last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= '0;
      b_q    <= '0;
      p_q    <= '0;
      mode_q <= MODE_LOAD;
    end else if (load) begin
      a_q    <= op_a_i;
      b_q    <= {{W{1'b0}}, op_b_i};
      p_q    <= '0;
      mode_q <= clmul_mode_e'(acc_i);
    end else if (busy) begin
      a_q <= a_ch[BITS_PER_CYC];
      b_q <= b_ch[BITS_PER_CYC];
      p_q <= p_ch[BITS_PER_CYC];
    end
  end

  clmul_hilo #(.W(W)) u_hilo (
    .clk_i, .rst_ni,
    .commit_i(last), .mode_i(mode_q), .prod_i(p_ch[BITS_PER_CYC]),
    .hi_o, .lo_o, .done_o, .ext_clr_o
  );

  p_prod_msb_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |-> !p_ch[BITS_PER_CYC][PW-1]);

  p_mode_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !last) |=> $stable(mode_q));

  initial begin
    assert (BITS_PER_CYC >= 1 && (W % BITS_PER_CYC) == 0)
      else $error("BITS_PER_CYC must divide W");
  end
endmodule

// File: tb/sim_clmul_acc.sv
module sim_clmul_acc;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int LAT = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, acc = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [W-1:0] hi, lo;
  logic ext_clr, done;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clmul_acc #(.W(W), .BITS_PER_CYC(1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .acc_i(acc),
    .op_a_i(op_a), .op_b_i(op_b), .hi_o(hi), .lo_o(lo),
    .ext_clr_o(ext_clr), .done_o(done)
  );

  function automatic logic [63:0] ref_clmul(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] r = '0;
    for (int i = 0; i < 32; i++)
      if (a[i]) r = r ^ ({32'b0, b} << i);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model: countdown per accepted start
  int          m_left = 0;
  logic [63:0] m_prod = '0;
  logic        m_acc = 1'b0;
  logic [31:0] m_hi = '0, m_lo = '0;
  logic        m_done = 1'b0, m_clr = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_left <= 0; m_hi <= '0; m_lo <= '0; m_done <= 1'b0; m_clr <= 1'b0;
    end else begin
      m_done <= 1'b0;
      m_clr  <= 1'b0;
      if (m_left > 0) begin
        m_left <= m_left - 1;
        if (m_left == 1) begin
          m_done <= 1'b1;
          m_clr  <= !m_acc;
          if (m_acc) begin
            m_hi <= m_hi ^ m_prod[63:32];
            m_lo <= m_lo ^ m_prod[31:0];
          end else begin
            m_hi <= m_prod[63:32];
            m_lo <= m_prod[31:0];
          end
        end
      end else if (start) begin
        m_left <= LAT;
        m_prod <= ref_clmul(op_a, op_b);
        m_acc  <= acc;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R6 done_o", 64'(done), 64'(m_done));
      chk("R5 ext_clr_o", 64'(ext_clr), 64'(m_clr));
      chk(m_acc ? "R4/R9 hi:lo" : "R3/R9 hi:lo", {hi, lo}, {m_hi, m_lo});
    end
  end

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic ac);
    @(negedge clk);
    start = 1'b1; op_a = a; op_b = b; acc = ac;
    @(negedge clk);
    start = 1'b0; op_a = ~a; op_b = ~b; acc = ~ac;
    repeat (LAT) @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset hi:lo", {hi, lo}, 64'h0);
    chk("R1 reset flags", {62'b0, done, ext_clr}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {hi, lo, 2'b0} | 66'(done) | 66'(ext_clr), 66'h0);

    run_op(32'h8000_0000, 32'h8000_0000, 1'b0);
    chk("R2 single bit hi", 64'(hi), 64'h4000_0000);
    chk("R2 single bit lo", 64'(lo), 64'h0);
    chk("R5 clr on load", 64'(ext_clr), 64'h1);
    @(negedge clk);

    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    chk("R2 all ones", {hi, lo}, ref_clmul(32'hFFFF_FFFF, 32'hFFFF_FFFF));
    chk("R8 msb zero", 64'(hi[31]), 64'h0);
    @(negedge clk);

    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    chk("R4 self cancel", {hi, lo}, 64'h0);
    chk("R5 no clr on xor", 64'(ext_clr), 64'h0);
    chk("R6 done on xor", 64'(done), 64'h1);
    @(negedge clk);

    run_op(32'h0000_0001, 32'hDEAD_BEEF, 1'b0);
    chk("R2 identity", {hi, lo}, 64'h0000_0000_DEAD_BEEF);
    run_op(32'h1234_5678, 32'h9ABC_DEF0, 1'b1);
    run_op(32'hA5A5_A5A5, 32'h0F0F_0F0F, 1'b1);
    run_op(32'h0000_0000, 32'hFFFF_FFFF, 1'b0);
    chk("R2 zero operand", {hi, lo}, 64'h0);

    // start while busy
    @(negedge clk);
    start = 1'b1; op_a = 32'h0000_0003; op_b = 32'h0000_0005; acc = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    start = 1'b1; op_a = 32'hFFFF_0000; op_b = 32'h1234_0000; acc = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (LAT - 11) @(negedge clk);
    chk("R7 busy start ignored", {hi, lo}, 64'h0000_0000_0000_000F);
    chk("R7 done timing", 64'(done), 64'h1);
    @(negedge clk);

    // idle with toggling inputs
    for (int i = 0; i < 8; i++) begin
      op_a = 32'(i * 32'h1111_1111); op_b = ~op_a; acc = i[0];
      @(negedge clk);
      chk("R9 idle hold", {hi, lo}, 64'h0000_0000_0000_000F);
    end

    for (int i = 0; i < 6; i++)
      run_op(32'h1 << (i * 5), 32'hC000_0001 ^ 32'(i), i[0]);
    repeat (3) @(negedge clk);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule